// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a synchronous state machine that turns single host requests into timed access cycles on an external asynchronous static RAM of 256K words by 8 bits. The host presents a one-cycle request with a read/write flag, an 18-bit word address and 8-bit write data. The controller then runs the memory's select, write-strobe and output-strobe pins and its tri-state data bus. It ends each access with a one-cycle `done` pulse. Read data is returned on `rd_data` and is held there until the next read.

Every memory timing figure is kept in nanoseconds for two speed grades. Grade 0 is the fast part and grade 1 is the slow part. At elaboration each figure is turned into a count of system clocks by rounding up, so an access never runs shorter than the part allows. The memory is selected only while both of its enables are active. One enable is active low and the other active high. Both are dropped between accesses, so the memory rests in standby whenever the controller is idle.

The states are:
- `ST_IDLE`: waiting for a request.
- `ST_RD_ACCESS`: the read is in progress and the data is sampled at its end.
- `ST_RD_RECOVER`: padding until the minimum read cycle time has passed.
- `ST_WR_GAP`: bus turnaround before the controller drives the data bus.
- `ST_WR_PULSE`: the write strobe is low.
- `ST_WR_HOLD`: address and data are held for one clock after the strobe.
- `ST_FINISH`: the done cycle, with the memory deselected.

The transitions are:
- `ST_IDLE` to `ST_RD_ACCESS` or to `ST_WR_GAP` when a request is accepted.
- `ST_RD_ACCESS` to `ST_RD_RECOVER` when the cycle time is longer than the sample point, otherwise to `ST_FINISH`.
- `ST_RD_RECOVER` to `ST_FINISH`.
- `ST_WR_GAP` to `ST_WR_PULSE`, then to `ST_WR_HOLD`, then to `ST_FINISH`.
- `ST_FINISH` to `ST_IDLE`.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `busy` and `done` are 0, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: `mem_sel` is always the inverse of `mem_sel_n`. The memory is selected only while `busy` is 1, and never in the done cycle.
- R3: A request is accepted only in idle. A `req_valid` pulse that arrives while `busy` is 1 is ignored and does not change memory contents.
- R4: During a read, `mem_we_n`=1, `mem_oe_n`=0 and `mem_dq_oe`=0. `rd_data` takes the bus value at the clock edge SAMP=ceil(max(t_aa,t_oe)/T) edges after the accepting edge.
- R5: `mem_addr` stays constant while the memory is selected. A read keeps the memory selected for max(SAMP, ceil(t_rc/T)) clocks.
- R6: During a write, `mem_oe_n` stays 1 throughout. `mem_dq_oe` stays 0 for the first FLT=ceil(max(t_ohz,t_chz)/T) clocks after acceptance.
- R7: During a write, `mem_we_n` is low for exactly WP=ceil(t_wp/T) clocks. `mem_dq_oe` is 1 during the pulse and for one clock after it, with address and data unchanged.
- R8: `done` is a one-cycle pulse and `busy` is 1 from the accepting edge through the done cycle. `done` rises after edge max(SAMP, RC) for a read and after edge FLT+WP+1 for a write. With grade 0 and T=8 ns these are edges 9 and 13.
- R9: `rd_data` keeps the last read value across following writes and idle time.
- R10: The grade sets the figures (t_rc, t_aa, t_oe, t_ohz, t_chz, t_wp) in ns. Grade 0 uses 70, 70, 35, 30, 35, 50. Grade 1 uses 100, 100, 50, 35, 40, 70. Each derived count is rounded up and is never less than 1.
- R11: The controller never drives the data bus while `mem_oe_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | One-cycle access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | Access complete pulse |
| rd_data | output | 8 | Last read data |
| mem_addr | output | 18 | Memory address |
| mem_sel_n | output | 1 | Active-low memory enable |
| mem_sel | output | 1 | Active-high memory enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output strobe |
| mem_dq_out | output | 8 | Data driven to the bus |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | 8 | Data seen on the bus |

## Verification
The checker watches several rules on every clock:
- the two enables stay paired and the memory is selected only while busy;
- the address is stable while selected;
- the controller never drives the bus while the output strobe is low;
- every rise of the bus driver enable comes after at least FLT clocks with both the output strobe and the driver off;
- every write strobe lasts exactly WP clocks;
- `done` is a single pulse.

Only the bench scenarios can show the rest:
- the exact latency of each access;
- that read data is sampled late enough, using a memory model that returns garbage before the access time;
- that data written is read back;
- that a request made during an access leaves memory untouched.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_RECOVER,
        ST_WR_GAP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_FINISH
    } ctrl_state_t;

    typedef enum int unsigned {
        TM_RC,
        TM_AA,
        TM_OE,
        TM_OHZ,
        TM_CHZ,
        TM_WP
    } timing_sel_t;

    // Timing figure in ns for a grade (0: fast, 1: slow).
    function automatic int unsigned grade_ns(int unsigned grade, timing_sel_t sel);
        int unsigned v;
        v = 1;
        unique case (sel)
            TM_RC:  v = (grade == 0) ? 70 : 100;
            TM_AA:  v = (grade == 0) ? 70 : 100;
            TM_OE:  v = (grade == 0) ? 35 : 50;
            TM_OHZ: v = (grade == 0) ? 30 : 35;
            TM_CHZ: v = (grade == 0) ? 35 : 40;
            TM_WP:  v = (grade == 0) ? 50 : 70;
            default: v = 1;
        endcase
        return v;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Round up to whole clocks, never below one clock.
    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_cycle_counter.sv
module sram_cycle_counter #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (capture) begin
            rdata_q <= bus_in;
        end
    end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned SAMP_C  = 9,
    parameter int unsigned RC_C    = 9,
    parameter int unsigned FLT_C   = 5,
    parameter int unsigned WP_C    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [CNT_W-1:0] count,
    output logic             cnt_clr,
    output logic             load,
    output logic             capture,
    output logic             busy,
    output logic             done,
    output logic             sel_on,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);
    localparam logic             HAS_RECOVER = (RC_C > SAMP_C);
    localparam int unsigned      RECOVER_C   = HAS_RECOVER ? (RC_C - SAMP_C) : 1;
    localparam logic [CNT_W-1:0] SAMP_LAST   = CNT_W'(SAMP_C - 1);
    localparam logic [CNT_W-1:0] REC_LAST    = CNT_W'(RECOVER_C - 1);
    localparam logic [CNT_W-1:0] FLT_LAST    = CNT_W'(FLT_C - 1);
    localparam logic [CNT_W-1:0] WP_LAST     = CNT_W'(WP_C - 1);

    ctrl_state_t state_q, state_d;

    // Next state and sequencing strobes.
    always_comb begin
        state_d = state_q;
        cnt_clr = 1'b0;
        load    = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    load    = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = req_write ? ST_WR_GAP : ST_RD_ACCESS;
                end
            end
            ST_RD_ACCESS: begin
                if (count == SAMP_LAST) begin
                    capture = 1'b1;
                    cnt_clr = 1'b1;
                    state_d = HAS_RECOVER ? ST_RD_RECOVER : ST_FINISH;
                end
            end
            ST_RD_RECOVER: begin
                if (count == REC_LAST) begin
                    state_d = ST_FINISH;
                end
            end
            ST_WR_GAP: begin
                if (count == FLT_LAST) begin
                    cnt_clr = 1'b1;
                    state_d = ST_WR_PULSE;
                end
            end
            ST_WR_PULSE: begin
                if (count == WP_LAST) begin
                    state_d = ST_WR_HOLD;
                end
            end
            ST_WR_HOLD: state_d = ST_FINISH;
            ST_FINISH:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Moore outputs decoded from the state register.
    always_comb begin
        busy   = 1'b1;
        done   = 1'b0;
        sel_on = 1'b0;
        we_n   = 1'b1;
        oe_n   = 1'b1;
        dq_oe  = 1'b0;
        unique case (state_q)
            ST_IDLE:       busy = 1'b0;
            ST_RD_ACCESS,
            ST_RD_RECOVER: begin
                sel_on = 1'b1;
                oe_n   = 1'b0;
            end
            ST_WR_GAP:     sel_on = 1'b1;
            ST_WR_PULSE: begin
                sel_on = 1'b1;
                we_n   = 1'b0;
                dq_oe  = 1'b1;
            end
            ST_WR_HOLD: begin
                sel_on = 1'b1;
                dq_oe  = 1'b1;
            end
            ST_FINISH:     done = 1'b1;
            default:       busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CLK_NS = 8,
    parameter int unsigned GRADE  = 0,
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned SAMP_CYC = ns_to_cyc(max2(grade_ns(GRADE, TM_AA), grade_ns(GRADE, TM_OE)), CLK_NS);
    localparam int unsigned RC_CYC   = ns_to_cyc(grade_ns(GRADE, TM_RC), CLK_NS);
    localparam int unsigned FLT_CYC  = ns_to_cyc(max2(grade_ns(GRADE, TM_OHZ), grade_ns(GRADE, TM_CHZ)), CLK_NS);
    localparam int unsigned WP_CYC   = ns_to_cyc(grade_ns(GRADE, TM_WP), CLK_NS);
    localparam int unsigned MAX_CYC  = max2(max2(SAMP_CYC, RC_CYC), max2(FLT_CYC, WP_CYC));
    localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

    logic [CNT_W-1:0] count;
    logic             cnt_clr, load, capture, sel_on;

    sram_cycle_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .count (count)
    );

    sram_seq_fsm #(
        .CNT_W  (CNT_W),
        .SAMP_C (SAMP_CYC),
        .RC_C   (RC_CYC),
        .FLT_C  (FLT_CYC),
        .WP_C   (WP_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .count     (count),
        .cnt_clr   (cnt_clr),
        .load      (load),
        .capture   (capture),
        .busy      (busy),
        .done      (done),
        .sel_on    (sel_on),
        .we_n      (mem_we_n),
        .oe_n      (mem_oe_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .bus_in    (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rd_data)
    );

    assign mem_sel_n = ~sel_on;
    assign mem_sel   = sel_on;
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
    parameter int unsigned FLT_CYC = 5,
    parameter int unsigned WP_CYC  = 7,
    parameter int unsigned ADDR_W  = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sel_n,
    input logic              mem_sel,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic [15:0] gap_cnt, we_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            we_cnt  <= '0;
        end else begin
            if (!mem_dq_oe && mem_oe_n) begin
                gap_cnt <= (gap_cnt == 16'hFFFF) ? gap_cnt : gap_cnt + 1'b1;
            end else begin
                gap_cnt <= '0;
            end
            we_cnt <= mem_we_n ? '0 : we_cnt + 1'b1;
        end
    end

    p_sel_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_sel == !mem_sel_n));
    p_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy || done) |-> mem_sel_n);
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));
    p_no_contention_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    p_float_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap_cnt >= 16'(FLT_CYC)));
    p_we_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_cnt == 16'(WP_CYC)));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
endmodule

bind sram_async_ctrl sram_ctrl_checker #(
    .FLT_CYC (FLT_CYC),
    .WP_CYC  (WP_CYC),
    .ADDR_W  (ADDR_W)
) u_sram_ctrl_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_sel_n (mem_sel_n),
    .mem_sel   (mem_sel),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
    localparam int CLK_NS = 8;
    // Grade 0 figures (R10): t_rc 70, t_aa 70, t_oe 35, t_ohz 30, t_chz 35, t_wp 50.
    localparam int EXP_SAMP = (70 + CLK_NS - 1) / CLK_NS;          // 9
    localparam int EXP_FLT  = (35 + CLK_NS - 1) / CLK_NS;          // 5
    localparam int EXP_WP   = (50 + CLK_NS - 1) / CLK_NS;          // 7
    localparam int EXP_RLAT = EXP_SAMP;                            // 9
    localparam int EXP_WLAT = EXP_FLT + EXP_WP + 1;                // 13

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  rd_data, mem_dq_out, mem_dq_in;
    logic [17:0] mem_addr;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_async_ctrl i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n),
        .mem_sel(mem_sel), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model: 1024 words on the low address bits, garbage before access time.
    logic [7:0] model_mem [1024];
    int         rd_age = 0;
    logic       rd_cond;
    assign rd_cond = !mem_sel_n && mem_sel && mem_we_n && !mem_oe_n;
    always @(posedge clk) rd_age <= rd_cond ? rd_age + 1 : 0;
    assign mem_dq_in = (rd_cond && ((rd_age + 1) * CLK_NS >= 70)) ? model_mem[mem_addr[9:0]] : 8'hEE;
    always @(posedge mem_we_n) begin
        if (rst_n && !mem_sel_n && mem_sel && mem_dq_oe)
            model_mem[mem_addr[9:0]] = mem_dq_out;
    end

    typedef struct { bit is_rd; logic [7:0] data; logic [17:0] addr; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] shadow [1024];

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops expected items on each done pulse.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(0, "R8 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.is_rd) check(rd_data == e.data, "R4 read data", rd_data, e.data);
            end
        end
    end

    // Bus and address rules watched across the run.
    always @(negedge clk) begin
        if (rst_n && mem_dq_oe && !mem_oe_n) check(0, "R11 contention", 1, 0);
    end

    task automatic access(bit wr, logic [17:0] a, logic [7:0] d,
                          bit inject, logic [17:0] ia, logic [7:0] idat);
        exp_t e;
        int   n = 0, we_low = 0, first_oe = -1;
        bit   bad_oe = 0, bad_drive = 0, busy_drop = 0, addr_move = 0;
        logic [17:0] a0;
        e.is_rd = !wr; e.addr = a; e.data = wr ? d : shadow[a[9:0]];
        if (wr) shadow[a[9:0]] = d;
        exp_q.push_back(e);
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        a0 = mem_addr;
        n = 1;
        while (!done && n < 100) begin
            if (!mem_we_n) we_low++;
            if (mem_dq_oe && first_oe < 0) first_oe = n;
            if (wr && !mem_oe_n) bad_oe = 1;
            if (!wr && (mem_dq_oe || !mem_we_n)) bad_drive = 1;
            if (!busy) busy_drop = 1;
            if (!mem_sel_n && mem_addr != a0) addr_move = 1;
            if (inject && n == 3) begin
                req_valid = 1; req_write = 1; req_addr = ia; req_wdata = idat;
            end else begin
                req_valid = 0;
            end
            @(negedge clk);
            n++;
        end
        req_valid = 0;
        check(busy, "R8 busy in done cycle", busy, 1);
        check(!busy_drop, "R8 busy held", busy_drop, 0);
        check(!addr_move, "R5 address stable", addr_move, 0);
        check(mem_sel_n && !mem_sel, "R2 deselect in done cycle", mem_sel_n, 1);
        if (wr) begin
            check(n - 1 == EXP_WLAT, "R8 R10 write latency", n - 1, EXP_WLAT);
            check(we_low == EXP_WP, "R7 write pulse width", we_low, EXP_WP);
            check(first_oe - 1 == EXP_FLT, "R6 bus turnaround", first_oe - 1, EXP_FLT);
            check(!bad_oe, "R6 oe high in write", bad_oe, 0);
        end else begin
            check(n - 1 == EXP_RLAT, "R4 R10 read latency", n - 1, EXP_RLAT);
            check(!bad_drive, "R4 read strobes", bad_drive, 0);
        end
        @(negedge clk);
        check(!busy && mem_sel_n && !done, "R2 standby after access", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            model_mem[i] = 8'(i * 7);
            shadow[i]    = 8'(i * 7);
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && mem_sel_n && !mem_sel && mem_we_n && mem_oe_n && !mem_dq_oe,
              "R1 reset outputs", {busy, done, mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe},
              7'b0010110);
        rst_n = 1;
        @(negedge clk);
        check(!busy && mem_sel_n, "R1 idle after reset", busy, 0);

        access(0, 18'h00005, 8'h00, 0, '0, '0);
        access(1, 18'h00000, 8'hA5, 0, '0, '0);
        access(1, 18'h3FFFF, 8'h5A, 0, '0, '0);
        access(0, 18'h00000, 8'h00, 0, '0, '0);
        access(0, 18'h3FFFF, 8'h00, 0, '0, '0);
        access(1, 18'h00123, 8'hFF, 0, '0, '0);
        // R9: the write above must leave rd_data alone.
        repeat (4) @(negedge clk);
        check(rd_data == 8'h5A, "R9 rd_data held", rd_data, 8'h5A);
        access(0, 18'h00123, 8'h00, 0, '0, '0);
        // R3: request injected mid-write to 0x200 is ignored.
        access(1, 18'h00077, 8'h3C, 1, 18'h00200, 8'h99);
        access(0, 18'h00200, 8'h00, 0, '0, '0);
        check(model_mem[10'h200] == shadow[10'h200], "R3 ignored request", model_mem[10'h200], shadow[10'h200]);
        access(0, 18'h00077, 8'h00, 0, '0, '0);
        // R3: request injected mid-read is ignored too.
        access(0, 18'h00005, 8'h00, 1, 18'h00201, 8'h11);
        check(model_mem[10'h201] == shadow[10'h201], "R3 ignored during read", model_mem[10'h201], shadow[10'h201]);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R8 all accesses completed", exp_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule